// File: doc/BRIEF.md
# SPI Byte-Addressed Memory Slave

This block is a 2048-byte random-access memory that answers as a slave on a four-wire SPI bus. Every transaction starts when the chip-select input falls. The host first sends a one-byte command and, for memory accesses, a two-byte address. After that it streams data bytes in or out for as long as chip-select stays low, and the address advances after every full byte. A write lands in the array within a few system-clock cycles of its last bit. This means that there is never a busy period, and the status register has no in-progress indication.

All pins are sampled by the block's own system clock through synchronizers. Data is taken on rising edges of the serial clock and driven out on falling edges. Because the logic reacts only to edges, it works the same way whether the host parks the serial clock low (mode 0) or high (mode 3), and no setting is needed. A write-enable latch guards both the memory write and the status write. The serial output is paired with an enable signal, so that the pad can be tri-stated while the block is not selected.

Top module: `spi_mem_slave`

## Requirements
- R1: SI is taken on rising SCK edges and SO changes on falling SCK edges, MSB first. The same traffic gives the same results whether SCK idles low (mode 0) or high (mode 3).
- R2: The command codes are 0x06 (set write-enable), 0x04 (clear write-enable), 0x05 (read status), 0x01 (write status), 0x03 (read memory) and 0x02 (write memory). Any other first byte makes the block ignore the rest of that select period. Only the first byte of a select period is decoded as a command.
- R3: For read and write, the two bytes after the command form a 16-bit address, high byte first. Only its low 11 bits select the location.
- R4: A read returns the byte at the address, then the bytes at each following address, wrapping from 0x7FF to 0x000.
- R5: A write stores each fully received data byte at the current address and then advances the address, with the same wrap. A data byte cut short by chip-select rising is discarded.
- R6: The write-enable latch is set by 0x06 and cleared by 0x04. It is also cleared when chip-select rises after a 0x02 or 0x01 command was received. Commands 0x02 and 0x01 change nothing if the latch was clear when the command arrived.
- R7: The status byte has the write-enable latch at bit 1, a two-bit protect field at bits 3:2, and zero in bit 0 (busy) and in bits 7:4. Command 0x01 loads only bits 3:2 from its data byte. The protect field is stored and read back only. Reading the status repeats the byte for as long as clocks continue.
- R8: The SO enable output is low whenever chip-select is high. It is high while read or status data is being shifted out.
- R9: After reset the write-enable latch and the protect field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCK rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | SPI chip-select, active low |
| sck_i | input | 1 | SPI serial clock |
| si_i | input | 1 | SPI serial data in |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | Output enable for the SO pad |

## Verification
A wrong bit counter or a wrong state shows up in the first byte after the address, as a shifted or foreign data value on SO. A wrong address register shows up as a mismatch at the burst position where it went wrong, which makes the wrap at 0x7FF the sharpest probe. A write-enable latch in the wrong state is only visible in the next select period, either in the status byte or as a read-back that should not have changed. For that reason every protection case is followed at once by a status read or a memory read.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_RD, ST_WR, ST_RDSR, ST_WRSR, ST_IDLE
  } state_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q[0] <= RST_VAL;
    else         q[0] <= d_i;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) q[g] <= RST_VAL;
      else         q[g] <= q[g-1];
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem[addr_i] <= wdata_i;

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  state_e            st_q;
  logic [2:0]        bit_q;
  logic [7:0]        sh_q, hi_q, tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sck_d, rd_q, wel_q, cmd_wen_q, wel_clr_q, so_q;
  logic [1:0]        bp_q;
  logic              rise, fall, byte_done, shifting;
  logic [7:0]        byte_v, status_v, src_v;

  assign rise      = sck_i & ~sck_d;
  assign fall      = ~sck_i & sck_d;
  assign byte_v    = {sh_q[6:0], si_i};
  assign byte_done = rise & ~cs_ni & (bit_q == 3'd7);
  assign status_v  = {4'b0000, bp_q, wel_q, 1'b0};
  assign shifting  = (st_q == ST_RD) || (st_q == ST_RDSR);
  assign src_v     = (st_q == ST_RD) ? mem_rdata_i : status_v;

  assign mem_we_o    = byte_done && (st_q == ST_WR) && cmd_wen_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = byte_v;
  assign so_o        = so_q;
  assign so_oe_o     = ~cs_ni & shifting;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OPC; bit_q <= '0; sh_q <= '0; hi_q <= '0; tx_q <= '0;
      addr_q <= '0; rd_q <= 1'b0; wel_q <= 1'b0; cmd_wen_q <= 1'b0;
      wel_clr_q <= 1'b0; so_q <= 1'b0; bp_q <= '0;
    end else if (cs_ni) begin
      // deselected: drop partial byte, finish deferred latch clear
      st_q <= ST_OPC; bit_q <= '0; sh_q <= '0; so_q <= 1'b0;
      if (wel_clr_q) wel_q <= 1'b0;
      wel_clr_q <= 1'b0;
    end else begin
      if (rise) begin
        sh_q  <= byte_v;
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          case (st_q)
            ST_OPC: begin
              case (byte_v)
                OP_WREN:  begin wel_q <= 1'b1; st_q <= ST_IDLE; end
                OP_WRDI:  begin wel_q <= 1'b0; st_q <= ST_IDLE; end
                OP_RDSR:  st_q <= ST_RDSR;
                OP_WRSR:  begin cmd_wen_q <= wel_q; wel_clr_q <= 1'b1; st_q <= ST_WRSR; end
                OP_READ:  begin rd_q <= 1'b1; st_q <= ST_AHI; end
                OP_WRITE: begin rd_q <= 1'b0; cmd_wen_q <= wel_q; wel_clr_q <= 1'b1; st_q <= ST_AHI; end
                default:  st_q <= ST_IDLE;
              endcase
            end
            ST_AHI: begin hi_q <= byte_v; st_q <= ST_ALO; end
            ST_ALO: begin
              addr_q <= ADDR_W'({hi_q, byte_v});
              st_q   <= rd_q ? ST_RD : ST_WR;
            end
            ST_RD, ST_WR: addr_q <= addr_q + 1'b1;
            ST_WRSR: begin
              if (cmd_wen_q) bp_q <= byte_v[3:2];
              st_q <= ST_IDLE;
            end
            default: ;
          endcase
        end
      end
      if (fall && shifting) begin
        if (bit_q == 3'd0) begin
          so_q <= src_v[7];
          tx_q <= {src_v[6:0], 1'b0};
        end else begin
          so_q <= tx_q[7];
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  // R5
  cs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (st_q == ST_OPC) && (bit_q == 3'd0));

  // R4
  addr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && (st_q == ST_RD || st_q == ST_WR)) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  // R6
  wel_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && wel_clr_q) |=> !wel_q);

  // R6
  wel_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && st_q == ST_OPC && byte_v == OP_WREN) |=> wel_q);

  // R2
  one_opc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && st_q != ST_OPC) |=> st_q != ST_OPC);
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o
);
  logic [2:0]        pins_q;
  logic              we;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata, rdata;

  spi_mem_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i({cs_ni, sck_i, si_i}), .q_o(pins_q)
  );

  spi_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_ni(pins_q[2]), .sck_i(pins_q[1]), .si_i(pins_q[0]),
    .so_o, .so_oe_o,
    .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  spi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk_i, .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );
endmodule

// File: tb/spi_mem_slave_tb_top.sv
`timescale 1ns/1ps
module spi_mem_slave_tb_top;
  localparam int HALF = 40;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  int   total = 0, fails = 0;
  bit   done = 1'b0;
  bit   mode3 = 1'b0;
  logic oe_seen;

  always #5 clk = ~clk;

  spi_mem_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe)
  );

  function automatic logic [7:0] pat(int a, int seed);
    return 8'((a * 37 + seed * 11 + 5) & 8'hFF);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sel;
    sck = mode3; #(HALF); cs_n = 1'b0; #(HALF);
  endtask

  task automatic desel;
    if (!mode3) begin sck = 1'b0; #(HALF); end
    cs_n = 1'b1; #(4*HALF);
  endtask

  task automatic xbits(input logic [7:0] d, input int n, output logic [7:0] q);
    q = '0; oe_seen = 1'b1;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = d[i]; #(HALF);
      q = {q[6:0], so}; oe_seen &= so_oe;
      sck = 1'b1; #(HALF);
    end
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] q);
    xbits(d, 8, q);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] q;
    sel; xbyte(op, q); desel;
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] q;
    sel; xbyte(8'h05, q); xbyte(8'h00, s); desel;
  endtask

  task automatic wr_burst(input logic [15:0] a, input int n, input int seed);
    logic [7:0] q;
    sel; xbyte(8'h02, q); xbyte(a[15:8], q); xbyte(a[7:0], q);
    for (int i = 0; i < n; i++) xbyte(pat((a + i) & 16'h7FF, seed), q);
    desel;
  endtask

  task automatic rd_check(input logic [15:0] a, input int n, input int seed, input string req);
    logic [7:0] q;
    sel; xbyte(8'h03, q); xbyte(a[15:8], q); xbyte(a[7:0], q);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, q);
      check(q === pat((a + i) & 16'h7FF, seed), req, q, pat((a + i) & 16'h7FF, seed));
    end
    check(oe_seen === 1'b1, "R8 oe during read", oe_seen, 1);
    desel;
  endtask

  task automatic rd1(input logic [15:0] a, output logic [7:0] d);
    logic [7:0] q;
    sel; xbyte(8'h03, q); xbyte(a[15:8], q); xbyte(a[7:0], q); xbyte(8'h00, d); desel;
  endtask

  initial begin
    logic [7:0] s, d, q;
    #(100); rst_n = 1'b1; #(100);

    // R9 / R8 reset state
    check(so_oe === 1'b0, "R8 oe idle", so_oe, 0);
    rdsr(s); check(s === 8'h00, "R9 status after reset", s, 8'h00);

    // R6 / R7 latch visible in status
    cmd1(8'h06); rdsr(s); check(s === 8'h02, "R6 wren sets latch", s, 8'h02);

    // R3 R4 R5 wrap burst, upper address bits junk, written mode 0 read mode 3
    wr_burst(16'hF7FC, 8, 1);
    check(so_oe === 1'b0, "R8 oe after deselect", so_oe, 0);
    rdsr(s); check(s === 8'h00, "R6 latch cleared after write", s, 8'h00);
    mode3 = 1'b1;
    rd_check(16'h07FC, 8, 1, "R4 wrap read mode3");
    rd_check(16'hA800, 3, 1, "R3 upper bits ignored");

    // R1 sweep, both modes over 64 addresses
    for (int m = 0; m < 2; m++) begin
      mode3 = bit'(m);
      cmd1(8'h06); wr_burst(16'h0100, 64, 2 + m);
      mode3 = ~bit'(m);
      rd_check(16'h0100, 64, 2 + m, "R1 mode sweep");
    end

    // R6 write without latch ignored
    mode3 = 1'b0;
    wr_burst(16'h0001, 1, 9);
    rd1(16'h0001, d); check(d === pat(1, 1), "R6 write blocked", d, pat(1, 1));
    cmd1(8'h06); cmd1(8'h04); rdsr(s); check(s === 8'h00, "R6 wrdi clears", s, 8'h00);
    wr_burst(16'h0002, 1, 9);
    rd1(16'h0002, d); check(d === pat(2, 1), "R6 write after wrdi blocked", d, pat(2, 1));

    // R5 partial byte discarded, wrap on write
    cmd1(8'h06);
    sel; xbyte(8'h02, q); xbyte(8'h07, q); xbyte(8'hFF, q); xbyte(8'hC3, q); xbits(8'hFF, 5, q); desel;
    rd1(16'h07FF, d); check(d === 8'hC3, "R5 full byte stored", d, 8'hC3);
    rd1(16'h0000, d); check(d === pat(0, 1), "R5 partial byte dropped", d, pat(0, 1));

    // R2 unknown opcode and second byte not decoded
    sel; xbyte(8'hAB, q); xbyte(8'h06, q); desel;
    rdsr(s); check(s === 8'h00, "R2 unknown opcode ignored", s, 8'h00);
    sel; xbyte(8'h05, q); xbyte(8'h06, q); desel;
    rdsr(s); check(s === 8'h00, "R2 one opcode per select", s, 8'h00);

    // R7 status write, repeat read, busy bit zero
    mode3 = 1'b1;
    cmd1(8'h06);
    sel; xbyte(8'h01, q); xbyte(8'hFF, q); desel;
    sel; xbyte(8'h05, q); xbyte(8'h00, s); xbyte(8'h00, d); desel;
    check(s === 8'h0C, "R7 status field", s, 8'h0C);
    check(d === 8'h0C, "R7 status repeats", d, 8'h0C);
    sel; xbyte(8'h01, q); xbyte(8'h00, q); desel;
    rdsr(s); check(s === 8'h0C, "R6 wrsr blocked", s, 8'h0C);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule